// File: doc/BRIEF.md
# Timer-Driven DRAM Refresh Sequencer

This block keeps dynamic memory alive by stealing the system bus at a steady rate. A prescaler divides the CPU clock by four. A programmable interval counter divides that slower clock again by a software-loaded divisor, which defaults to 18. The result is one refresh tick every 72 CPU clocks.

Each tick starts a one-byte dummy read. The channel raises a bus request and waits for the grant. It then keeps the bus for a fixed window of CPU clocks, during which no other transfer may begin. In the first cycle of that window it strobes one read at the current refresh address, and the address then moves on by one. Because consecutive refreshes walk through consecutive addresses, every row of the memory is touched in turn.

Software can lower the refresh rate by loading a larger divisor. It can also switch refresh off entirely, so that cycle-counted code runs with no bus stalls. While refresh is off, the address holds its value.

The channel runs a three-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Nothing pending. |
| `ST_REQUEST` | Bus requested, waiting for the grant. |
| `ST_STEAL` | Bus held for the refresh window. |

It moves between them on three transitions:

| Transition | Cause |
|---|---|
| `ST_IDLE` → `ST_REQUEST` | A terminal tick of the interval counter. |
| `ST_REQUEST` → `ST_STEAL` | `bus_grant` is sampled high. |
| `ST_STEAL` → `ST_IDLE` | The last cycle of the window ends. |

A tick that lands while the machine is outside `ST_IDLE` is reported on `overrun` and is dropped, not queued.

Top module: `refresh_sequencer`

## Requirements
- R1: While reset is held, `bus_req`, `hold_active`, `rd_strobe` and `overrun` are 0, and `rfsh_addr` is 0.
- R2: With `bus_grant` held high, successive `rd_strobe` pulses are PRESCALE×divisor clocks apart. The defaults are PRESCALE=4 and divisor 18, giving 72 clocks.
- R3: `bus_req` rises one clock after a terminal tick. It stays high for as long as `bus_grant` is low, and `hold_active` never rises without `bus_req` and `bus_grant` having been high in the previous clock.
- R4: `hold_active` is high for exactly HOLD_CYCLES (default 4) consecutive clocks. The window starts in the clock after the grant is sampled, and `bus_req` stays high throughout it.
- R5: Each refresh gives exactly one single-clock `rd_strobe`, in the first clock of the hold window.
- R6: `rfsh_addr` rises by exactly one after each `rd_strobe` and is otherwise stable. It wraps from 2^ADDR_W−1 to 0, where ADDR_W defaults to 16.
- R7: A divisor written through `div_wr`/`div_data` does not change the period in progress. It governs the period after the next terminal count. A written value of 0 is used as 1.
- R8: While `enable` is low, no new request starts and the address holds. After `enable` rises, the first `rd_strobe` comes PRESCALE×divisor+1 clocks after the first enabled clock edge.
- R9: A terminal tick that arrives outside `ST_IDLE` produces a one-clock `overrun` pulse, in the clock after that tick. It adds no further refresh: one grant yields one strobe, and `bus_req` then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Refresh on (1) or off (0) |
| div_wr | input | 1 | Load strobe for the divisor |
| div_data | input | DIV_W | New divisor value |
| bus_grant | input | 1 | Bus granted to the refresh channel |
| bus_req | output | 1 | Bus requested or held |
| hold_active | output | 1 | Refresh window in progress |
| rd_strobe | output | 1 | One-clock dummy byte read |
| rfsh_addr | output | ADDR_W | Address of the current refresh read |
| overrun | output | 1 | A tick was dropped while a refresh was pending |

## Verification
The bench sweeps the divisor from 2 to 20 and measures the interval on each side of every change. A design that reloaded the count mid-period would show a first interval of the wrong length. A narrow address counter is run past its wrap, so an off-by-one or a missing wrap shows up as a wrong address on some strobe. A withheld grant spans two later ticks. A design that queued those ticks would produce extra strobes or skip the address, and one that lacked overrun detection would show the wrong pulse count. Disabling refresh mid-period and then re-enabling it checks for stray requests, a drifting address, and a timer that resumes with a stale partial count.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    // Refresh channel states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQUEST = 2'd1,
        ST_STEAL   = 2'd2
    } rfsh_state_t;

endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pre_tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE == 1) begin : g_bypass
            assign pre_tick = run;
        end else begin : g_count
            logic [PW-1:0] pre_cnt;

            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    pre_cnt <= '0;
                end else if (pre_cnt == PW'(PRESCALE - 1)) begin
                    pre_cnt <= '0;
                end else begin
                    pre_cnt <= pre_cnt + 1'b1;
                end
            end

            assign pre_tick = run && (pre_cnt == PW'(PRESCALE - 1));
        end
    endgenerate
endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
    parameter int DIV_W       = 16,
    parameter int DEFAULT_DIV = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_tick,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_data,
    output logic             term_tick
);
    logic [DIV_W-1:0] pending_div;
    logic [DIV_W-1:0] div_cnt;

    // Divisor staging register: zero is used as one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_div <= DIV_W'(DEFAULT_DIV);
        end else if (div_wr) begin
            pending_div <= (div_data == '0) ? DIV_W'(1) : div_data;
        end
    end

    // Down counter; reloads only at terminal count or while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= DIV_W'(DEFAULT_DIV);
        end else if (!run) begin
            div_cnt <= pending_div;
        end else if (pre_tick) begin
            if (div_cnt <= DIV_W'(1)) begin
                div_cnt <= pending_div;
            end else begin
                div_cnt <= div_cnt - 1'b1;
            end
        end
    end

    assign term_tick = run && pre_tick && (div_cnt <= DIV_W'(1));
endmodule

// File: rtl/rfsh_channel.sv
module rfsh_channel
    import rfsh_pkg::*;
#(
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic term_tick,
    input  logic bus_grant,
    output logic bus_req,
    output logic hold_active,
    output logic rd_strobe,
    output logic overrun
);
    localparam int HC_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;

    rfsh_state_t     state, state_nxt;
    logic [HC_W-1:0] hold_cnt;
    logic            overrun_q;
    logic            window_done;

    assign window_done = (hold_cnt == HC_W'(HOLD_CYCLES - 1));

    // Next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (term_tick)   state_nxt = ST_REQUEST;
            ST_REQUEST: if (bus_grant)   state_nxt = ST_STEAL;
            ST_STEAL:   if (window_done) state_nxt = ST_IDLE;
            default:                     state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Window counter and dropped-tick flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt  <= '0;
            overrun_q <= 1'b0;
        end else begin
            overrun_q <= term_tick && (state != ST_IDLE);
            if (state == ST_STEAL && !window_done) begin
                hold_cnt <= hold_cnt + 1'b1;
            end else begin
                hold_cnt <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        bus_req     = 1'b0;
        hold_active = 1'b0;
        rd_strobe   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_REQUEST: bus_req = 1'b1;
            ST_STEAL: begin
                bus_req     = 1'b1;
                hold_active = 1'b1;
                rd_strobe   = (hold_cnt == '0);
            end
            default: ;
        endcase
        overrun = overrun_q;
    end
endmodule

// File: rtl/rfsh_addr_ctr.sv
module rfsh_addr_ctr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);
    // Natural binary wrap from all-ones to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (advance) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer #(
    parameter int PRESCALE    = 4,
    parameter int DIV_W       = 16,
    parameter int DEFAULT_DIV = 18,
    parameter int HOLD_CYCLES = 4,
    parameter int ADDR_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_data,
    input  logic              bus_grant,
    output logic              bus_req,
    output logic              hold_active,
    output logic              rd_strobe,
    output logic [ADDR_W-1:0] rfsh_addr,
    output logic              overrun
);
    logic pre_tick;
    logic term_tick;

    rfsh_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .pre_tick (pre_tick)
    );

    rfsh_interval #(.DIV_W(DIV_W), .DEFAULT_DIV(DEFAULT_DIV)) u_ivl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .pre_tick  (pre_tick),
        .div_wr    (div_wr),
        .div_data  (div_data),
        .term_tick (term_tick)
    );

    rfsh_channel #(.HOLD_CYCLES(HOLD_CYCLES)) u_chan (
        .clk         (clk),
        .rst_n       (rst_n),
        .term_tick   (term_tick),
        .bus_grant   (bus_grant),
        .bus_req     (bus_req),
        .hold_active (hold_active),
        .rd_strobe   (rd_strobe),
        .overrun     (overrun)
    );

    rfsh_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (rd_strobe),
        .addr    (rfsh_addr)
    );
endmodule

// File: rtl/refresh_sequencer_chk.sv
module refresh_sequencer_chk #(
    parameter int HOLD_CYCLES = 4,
    parameter int ADDR_W      = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_grant,
    input logic              bus_req,
    input logic              hold_active,
    input logic              rd_strobe,
    input logic [ADDR_W-1:0] rfsh_addr
);
    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (hold_active) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R4
    hold_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> bus_req);

    // R4
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_active) |-> (run_len == 16'(HOLD_CYCLES)));

    // R3
    grant_before_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active) |-> ($past(bus_grant) && $past(bus_req)));

    // R3
    req_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !hold_active && !bus_grant) |=> bus_req);

    // R5
    strobe_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> $rose(hold_active));

    // R5
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rd_strobe);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> (rfsh_addr == ADDR_W'($past(rfsh_addr) + 1'b1)));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rfsh_addr));
endmodule

bind refresh_sequencer refresh_sequencer_chk #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_grant   (bus_grant),
    .bus_req     (bus_req),
    .hold_active (hold_active),
    .rd_strobe   (rd_strobe),
    .rfsh_addr   (rfsh_addr)
);

// File: tb/refresh_sequencer_test.sv
module refresh_sequencer_test;
    localparam int PRE   = 4;
    localparam int DIV_W = 16;
    localparam int HOLD  = 4;
    localparam int AW    = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b1;
    logic             div_wr = 1'b0;
    logic [DIV_W-1:0] div_data = '0;
    logic             bus_grant = 1'b1;
    logic             bus_req, hold_active, rd_strobe, overrun;
    logic [AW-1:0]    rfsh_addr;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;
    int  exp_addr = 0;
    int  hold_run = 0;

    always #10 clk = ~clk;

    refresh_sequencer #(
        .PRESCALE(PRE), .DIV_W(DIV_W), .DEFAULT_DIV(18),
        .HOLD_CYCLES(HOLD), .ADDR_W(AW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_wr(div_wr),
        .div_data(div_data), .bus_grant(bus_grant), .bus_req(bus_req),
        .hold_active(hold_active), .rd_strobe(rd_strobe),
        .rfsh_addr(rfsh_addr), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_strobe(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rd_strobe && n < 5000);
    endtask

    // R6: every strobe carries the next address, wrapping at 2^AW
    always @(negedge clk) begin
        if (rst_n && rd_strobe) begin
            check(rfsh_addr == AW'(exp_addr), "R6", "strobe address", rfsh_addr, exp_addr);
            exp_addr = (exp_addr + 1) % (1 << AW);
        end
    end

    // R4: each hold window lasts HOLD clocks with bus_req high
    always @(negedge clk) begin
        if (rst_n && hold_active) begin
            hold_run++;
            if (!bus_req) check(1'b0, "R4", "bus_req during hold", 0, 1);
        end else if (hold_run != 0) begin
            check(hold_run == HOLD, "R4", "hold length", hold_run, HOLD);
            hold_run = 0;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int n, old_div, a0, cnt, ovr, hseen, strb;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(bus_req == 0 && hold_active == 0 && rd_strobe == 0 && overrun == 0,
              "R1", "outputs in reset", {bus_req, hold_active, rd_strobe, overrun}, 0);
        check(rfsh_addr == 0, "R1", "address in reset", rfsh_addr, 0);
        rst_n = 1'b1;

        // R2 default period
        wait_strobe(n);
        check(n == PRE * 18 + 1, "R2", "first strobe after reset", n, PRE * 18 + 1);
        for (int i = 0; i < 2; i++) begin
            wait_strobe(n);
            check(n == PRE * 18, "R2", "default period", n, PRE * 18);
        end

        // R7 / R2 divisor sweep
        old_div = 18;
        for (int d = 2; d <= 20; d++) begin
            div_wr = 1'b1;
            div_data = DIV_W'(d);
            @(negedge clk);
            div_wr = 1'b0;
            wait_strobe(n);
            check(n + 1 == PRE * old_div, "R7", "period in progress kept", n + 1, PRE * old_div);
            wait_strobe(n);
            check(n == PRE * d, "R2", "new divisor period", n, PRE * d);
            old_div = d;
        end

        // R6 run past the address wrap with divisor 5
        div_wr = 1'b1;
        div_data = DIV_W'(5);
        @(negedge clk);
        div_wr = 1'b0;
        wait_strobe(n);
        for (int i = 0; i < 70; i++) begin
            wait_strobe(n);
            check(n == PRE * 5, "R2", "period across wrap", n, PRE * 5);
        end

        // R8 disable mid-period
        enable = 1'b0;
        repeat (8) @(negedge clk);
        a0 = rfsh_addr;
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bus_req) cnt++;
        end
        check(cnt == 0, "R8", "requests while disabled", cnt, 0);
        check(rfsh_addr == AW'(a0), "R8", "address held while disabled", rfsh_addr, a0);
        enable = 1'b1;
        wait_strobe(n);
        check(n == PRE * 5 + 1, "R8", "first strobe after enable", n, PRE * 5 + 1);

        // R3 / R9 late grant
        bus_grant = 1'b0;
        ovr = 0;
        hseen = 0;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (overrun) ovr++;
            if (k > 4 && hold_active) hseen++;
        end
        check(bus_req == 1, "R3", "request held without grant", bus_req, 1);
        check(hseen == 0, "R3", "hold without grant", hseen, 0);
        check(ovr == 2, "R9", "overrun pulses", ovr, 2);
        a0 = rfsh_addr;
        bus_grant = 1'b1;
        strb = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (rd_strobe) strb++;
        end
        check(strb == 1, "R9", "one strobe per grant", strb, 1);
        check(rfsh_addr == AW'(a0 + 1), "R9", "address after late grant", rfsh_addr, (a0 + 1) % (1 << AW));
        check(bus_req == 0, "R9", "no queued request", bus_req, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule